// File: doc/BRIEF.md
# Register-File Byte Burst Mover

This block copies a run of bytes in either direction between a byte-wide, byte-addressed data memory and a register file. The register file is held outside the block and has 32 entries of 32 bits. A command names a direction, a start memory address, a byte count and a start position in the register file. The start position is a register index plus a byte lane inside that register. The engine moves one byte per memory access. Each later byte uses the next memory address and the next register byte position, and position 3 of one register is followed by position 0 of the next register.

Before any access takes place, the command goes through three checks:

- an optional trap on the lowest memory words;
- a check against a configurable instruction-space boundary;
- a check that the transfer stays inside the register file.

A command that fails a check finishes at once with an error code and writes nothing. Loads write the register file one byte lane at a time, with a byte-enable mask. The memory read port has one cycle of latency, and the engine waits out that latency before it writes each byte.

Top module: `rfx_burst_engine`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_req_o, mem_we_o and reg_we_o are all 0.
- R2: Byte i of a transfer (i from 0) pairs memory address addr_i+i with register byte position P = reg_i*4 + lane_i + i. P selects register P/4 and lane P%4, and lane k covers bits 8k+7..8k. The lowest address therefore pairs with the lowest position, and the walk wraps from lane 3 to lane 0 of the next register.
- R3: The memory address increases by exactly one for each byte transferred.
- R4: A load writes each byte with reg_be_o one-hot on its own lane, so the other three lanes of that register keep their values.
- R5: A command with reg_i*4 + lane_i + count_i > 128 is refused with err_code_o = 3. A command that ends exactly at byte 128 is accepted.
- R6: When null_trap_en_i is 1, a command with addr_i < 4 is refused with err_code_o = 1. When null_trap_en_i is 0, such an address is allowed.
- R7: A command with addr_i >= iws_base_i, or with addr_i + count_i > iws_base_i, is refused with err_code_o = 2. A command that ends exactly at iws_base_i is accepted.
- R8: When several checks fail, the reported code follows this priority: null trap (1) first, then window (2), then length (3).
- R9: A refused command raises done_o and err_o for one cycle, in the cycle after it is accepted. busy_o never rises for it, and it makes no memory or register writes.
- R10: A command with count_i = 0 that passes all checks raises done_o with err_o = 0 and err_code_o = 0 in the cycle after it is accepted, and it makes no accesses.
- R11: A store moves one byte per cycle, and done_o rises count_i cycles after the cycle in which busy_o first rises. A load uses two cycles per byte: a read request, then the register write of the returned data in the next cycle. Its done_o rises 2*count_i cycles after busy_o first rises.
- R12: start_i is ignored while busy_o is 1.
- R13: done_o is a single-cycle pulse, and err_code_o is valid while done_o is 1 (0 means success).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken only when idle |
| dir_store_i | input | 1 | 1 = register to memory, 0 = memory to register |
| addr_i | input | 32 | Start memory byte address |
| count_i | input | 8 | Byte count, 0..128 |
| reg_i | input | 5 | Start register index |
| lane_i | input | 2 | Start byte lane within the register |
| null_trap_en_i | input | 1 | Enable the low-address trap |
| iws_base_i | input | 32 | Instruction-space base; data accesses must stay below it |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Completion was a refusal |
| err_code_o | output | 2 | 0 ok, 1 null trap, 2 window, 3 length |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, one cycle after a read request |
| reg_ridx_o | output | 5 | Register read index (combinational read) |
| reg_rdata_i | input | 32 | Register read data |
| reg_we_o | output | 1 | Register write enable |
| reg_widx_o | output | 5 | Register write index |
| reg_be_o | output | 4 | Register byte-lane enables |
| reg_wdata_o | output | 32 | Register write data (byte replicated) |

## Verification
The bench aims at the points where the walk crosses a register boundary and at the last byte of the register file. A design that wrapped lanes wrongly would corrupt the wrong register, and one that ended one byte early would refuse a legal command. It also tests the window boundary on both sides of iws_base_i: an off-by-one there either lets a byte into instruction space or rejects a legal transfer. Commands that fail several checks at once expose a wrong priority as a wrong code. For refused commands, the bench counts every memory and register write, so any side effect is caught. Latency is measured per command, so a load that wrote before the read data arrived, or a store that stalled, shows up as a wrong cycle count. A second start issued while busy must leave memory untouched.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NULL   = 2'd1,
    ERR_WINDOW = 2'd2,
    ERR_LENGTH = 2'd3
  } rfx_err_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STORE,
    ST_LD_REQ,
    ST_LD_WR
  } rfx_state_e;
endpackage

// File: rtl/rfx_range_check.sv
module rfx_range_check
  import rfx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 8,
  parameter int PW        = 7,
  parameter int TOTAL     = 128,
  parameter int NULL_SPAN = 4
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [PW-1:0] pos_i,
  input  logic          null_en_i,
  input  logic [AW-1:0] base_i,
  output rfx_err_e      code_o
);
  localparam int SW = (PW > CW ? PW : CW) + 1;

  logic [AW:0]   end_addr;
  logic [SW-1:0] span;
  logic          null_hit, win_hit, len_hit;

  assign end_addr = {1'b0, addr_i} + (AW+1)'(count_i);
  assign span     = SW'(pos_i) + SW'(count_i);
  assign null_hit = null_en_i && (addr_i < AW'(NULL_SPAN));
  assign win_hit  = (addr_i >= base_i) || (end_addr > {1'b0, base_i});
  assign len_hit  = span > SW'(TOTAL);

  // fixed priority: null, window, length
  always_comb begin
    if (null_hit)      code_o = ERR_NULL;
    else if (win_hit)  code_o = ERR_WINDOW;
    else if (len_hit)  code_o = ERR_LENGTH;
    else               code_o = ERR_NONE;
  end
endmodule

// File: rtl/rfx_walker.sv
module rfx_walker #(
  parameter int AW = 32,
  parameter int PW = 7,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [PW-1:0] pos_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] addr_o,
  output logic [PW-1:0] pos_o,
  output logic          last_o
);
  logic [CW-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      pos_o    <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      addr_o   <= addr_i;
      pos_o    <= pos_i;
      remain_q <= cnt_i;
    end else if (adv_i) begin
      addr_o   <= addr_o + AW'(1);
      pos_o    <= pos_o + PW'(1);  // lane carry walks into the next register
      remain_q <= remain_q - CW'(1);
    end
  end

  assign last_o = (remain_q == CW'(1));
endmodule

// File: rtl/rfx_burst_engine.sv
module rfx_burst_engine
  import rfx_pkg::*;
#(
  parameter int AW        = 32,
  parameter int NREG      = 32,
  parameter int BPR       = 4,
  parameter int NULL_SPAN = 4,
  localparam int RW    = $clog2(NREG),
  localparam int LW    = $clog2(BPR),
  localparam int PW    = RW + LW,
  localparam int TOTAL = NREG * BPR,
  localparam int CW    = $clog2(TOTAL + 1),
  localparam int DW    = BPR * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dir_store_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] count_i,
  input  logic [RW-1:0] reg_i,
  input  logic [LW-1:0] lane_i,
  input  logic          null_trap_en_i,
  input  logic [AW-1:0] iws_base_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_code_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [RW-1:0] reg_ridx_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_we_o,
  output logic [RW-1:0] reg_widx_o,
  output logic [BPR-1:0] reg_be_o,
  output logic [DW-1:0] reg_wdata_o
);
  rfx_state_e    state_q;
  rfx_err_e      chk_code, code_q;
  logic          done_q;
  logic          accept, launch, adv, last;
  logic [AW-1:0] cur_addr;
  logic [PW-1:0] cur_pos;
  logic [RW-1:0] cur_reg;
  logic [LW-1:0] cur_lane;
  logic [BPR-1:0] lane_dec;

  rfx_range_check #(
    .AW(AW), .CW(CW), .PW(PW), .TOTAL(TOTAL), .NULL_SPAN(NULL_SPAN)
  ) u_chk (
    .addr_i   (addr_i),
    .count_i  (count_i),
    .pos_i    ({reg_i, lane_i}),
    .null_en_i(null_trap_en_i),
    .base_i   (iws_base_i),
    .code_o   (chk_code)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign launch = accept && (chk_code == ERR_NONE) && (count_i != '0);
  assign adv    = (state_q == ST_STORE) || (state_q == ST_LD_WR);

  rfx_walker #(.AW(AW), .PW(PW), .CW(CW)) u_walk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(launch),
    .adv_i (adv),
    .addr_i(addr_i),
    .pos_i ({reg_i, lane_i}),
    .cnt_i (count_i),
    .addr_o(cur_addr),
    .pos_o (cur_pos),
    .last_o(last)
  );

  assign cur_reg  = cur_pos[PW-1:LW];
  assign cur_lane = cur_pos[LW-1:0];

  for (genvar g = 0; g < BPR; g++) begin : g_lane
    assign lane_dec[g] = (cur_lane == LW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (chk_code != ERR_NONE || count_i == '0) begin
            done_q <= 1'b1;
            code_q <= chk_code;
          end else begin
            code_q  <= ERR_NONE;
            state_q <= dir_store_i ? ST_STORE : ST_LD_REQ;
          end
        end
        ST_STORE: if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        ST_LD_REQ: state_q <= ST_LD_WR;
        ST_LD_WR: begin
          state_q <= last ? ST_IDLE : ST_LD_REQ;
          done_q  <= last;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = done_q && (code_q != ERR_NONE);
  assign err_code_o  = code_q;

  assign mem_req_o   = (state_q == ST_STORE) || (state_q == ST_LD_REQ);
  assign mem_we_o    = (state_q == ST_STORE);
  assign mem_addr_o  = cur_addr;
  assign reg_ridx_o  = cur_reg;
  assign mem_wdata_o = reg_rdata_i[{cur_lane, 3'b000} +: 8];

  // read data arrives one cycle after ST_LD_REQ
  assign reg_we_o    = (state_q == ST_LD_WR);
  assign reg_widx_o  = cur_reg;
  assign reg_be_o    = reg_we_o ? lane_dec : '0;
  assign reg_wdata_o = {BPR{mem_rdata_i}};

  // R4
  be_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $countones(reg_be_o) == 1);
  // R11
  ld_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(mem_req_o && !mem_we_o));
  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(1));
  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !mem_req_o && !reg_we_o));
  // R13
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

// File: tb/rfx_burst_engine_tb.sv
`timescale 1ns/1ps
module rfx_burst_engine_tb;
  typedef struct packed {
    logic        st;
    logic [31:0] addr;
    logic [7:0]  cnt;
    logic [4:0]  rg;
    logic [1:0]  ln;
    logic        nen;
    logic [31:0] base;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 14;
  // dir, addr, cnt, reg, lane, null_en, base, expected code
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h10, 8'd4,  5'd0,  2'd0, 1'b1, 32'h100, 2'd0},  // R2 aligned load
    '{1'b0, 32'h21, 8'd7,  5'd3,  2'd2, 1'b1, 32'h100, 2'd0},  // R2 wrap
    '{1'b1, 32'h40, 8'd9,  5'd3,  2'd1, 1'b1, 32'h100, 2'd0},  // R3 store wrap
    '{1'b1, 32'h80, 8'd1,  5'd31, 2'd3, 1'b1, 32'h100, 2'd0},  // R5 last byte ok
    '{1'b0, 32'h90, 8'd2,  5'd31, 2'd3, 1'b1, 32'h100, 2'd3},  // R5 one over
    '{1'b0, 32'h02, 8'd4,  5'd5,  2'd0, 1'b1, 32'h100, 2'd1},  // R6 trap
    '{1'b0, 32'h02, 8'd4,  5'd5,  2'd0, 1'b0, 32'h100, 2'd0},  // R6 trap off
    '{1'b1, 32'hFC, 8'd4,  5'd7,  2'd0, 1'b1, 32'h100, 2'd0},  // R7 ends at base
    '{1'b1, 32'hFD, 8'd4,  5'd7,  2'd0, 1'b1, 32'h100, 2'd2},  // R7 crosses
    '{1'b0, 32'h100, 8'd0, 5'd0,  2'd0, 1'b1, 32'h100, 2'd2},  // R7 start at base
    '{1'b0, 32'h30, 8'd0,  5'd0,  2'd0, 1'b1, 32'h100, 2'd0},  // R10 zero length
    '{1'b0, 32'h01, 8'd5,  5'd31, 2'd3, 1'b1, 32'h01,  2'd1},  // R8 all three
    '{1'b1, 32'hF0, 8'd20, 5'd31, 2'd0, 1'b1, 32'h100, 2'd2},  // R8 window+length
    '{1'b0, 32'h60, 8'd16, 5'd10, 2'd0, 1'b1, 32'h100, 2'd0}   // R4 long load
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, dir_store_i = 1'b0, null_trap_en_i = 1'b0;
  logic [31:0] addr_i = '0, iws_base_i = 32'h100;
  logic [7:0]  count_i = '0;
  logic [4:0]  reg_i = '0;
  logic [1:0]  lane_i = '0;
  logic        busy_o, done_o, err_o, mem_req_o, mem_we_o, reg_we_o;
  logic [1:0]  err_code_o;
  logic [31:0] mem_addr_o, reg_rdata_i, reg_wdata_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic [4:0]  reg_ridx_o, reg_widx_o;
  logic [3:0]  reg_be_o;

  logic [7:0]  mem [512];
  logic [31:0] regs [32];
  logic [7:0]  exp_mem [512];
  logic [31:0] exp_regs [32];
  int          n_chk = 0, n_bad = 0, wr_cnt = 0;

  always #4 clk_i = ~clk_i;

  rfx_burst_engine u_dut (.*);

  assign reg_rdata_i = regs[reg_ridx_o];
  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o[8:0]] <= mem_wdata_o;
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[8:0]];
    if (reg_we_o)
      for (int k = 0; k < 4; k++)
        if (reg_be_o[k]) regs[reg_widx_o][k*8 +: 8] <= reg_wdata_o[k*8 +: 8];
    if (rst_ni && ((mem_req_o && mem_we_o) || reg_we_o)) wr_cnt <= wr_cnt + 1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model(input vec_t v);
    for (int i = 0; i < int'(v.cnt); i++) begin
      int p = int'(v.rg) * 4 + int'(v.ln) + i;
      int a = int'(v.addr) + i;
      if (v.st) exp_mem[a] = exp_regs[p/4][(p%4)*8 +: 8];
      else      exp_regs[p/4][(p%4)*8 +: 8] = exp_mem[a];
    end
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    for (int i = 0; i < 32; i++) if (regs[i] !== exp_regs[i]) bad++;
    check({req, " regs"}, bad, 0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
    check({req, " mem"}, bad, 0);
  endtask

  task automatic drive(input vec_t v);
    dir_store_i = v.st; addr_i = v.addr; count_i = v.cnt; reg_i = v.rg;
    lane_i = v.ln; null_trap_en_i = v.nen; iws_base_i = v.base;
    start_i = 1'b1;
  endtask

  task automatic run(input vec_t v, output int lat);
    lat = 0;
    drive(v);
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end while (!done_o && lat < 1000);
  endtask

  initial begin
    int lat, w0, exp_lat;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 37 + 5); exp_mem[i] = 8'(i * 37 + 5);
    end
    for (int i = 0; i < 32; i++) begin
      regs[i] = 32'hA5000000 ^ (i * 32'h01030507); exp_regs[i] = regs[i];
    end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", {busy_o, done_o, err_o, mem_req_o, mem_we_o, reg_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {busy_o, done_o, reg_we_o}, 0);

    for (int j = 0; j < NV; j++) begin
      vec_t v = VECS[j];
      if (v.code == 2'd0) model(v);
      exp_lat = (v.code != 0 || v.cnt == 0) ? 1 :
                v.st ? int'(v.cnt) + 1 : 2 * int'(v.cnt) + 1;
      w0 = wr_cnt;
      run(v, lat);
      check($sformatf("R5/R6/R7/R8 code vec%0d", j), err_code_o, v.code);
      check($sformatf("R9 err flag vec%0d", j), err_o, v.code != 0);
      check($sformatf("R11 latency vec%0d", j), lat, exp_lat);
      if (v.code != 0 || v.cnt == 0)
        check($sformatf("R9/R10 no writes vec%0d", j), wr_cnt - w0, 0);
      @(negedge clk_i);
      check($sformatf("R13 pulse vec%0d", j), done_o, 0);
      compare_all($sformatf("R2/R3/R4 vec%0d", j));
    end

    // R12 second start while busy is ignored
    begin
      vec_t a = '{1'b0, 32'h48, 8'd4, 5'd8, 2'd1, 1'b0, 32'h100, 2'd0};
      vec_t b = '{1'b1, 32'hC0, 8'd8, 5'd0, 2'd0, 1'b0, 32'h100, 2'd0};
      model(a);
      lat = 0;
      drive(a);
      @(negedge clk_i); lat++;
      drive(b);
      do begin
        @(negedge clk_i);
        start_i = 1'b0;
        lat++;
      end while (!done_o && lat < 1000);
      check("R12 latency", lat, 9);
      @(negedge clk_i);
      check("R12 idle after", busy_o, 0);
      compare_all("R12");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule